// File: doc/BRIEF.md
# Digit-Parallel GF(2^163) Multiplier

This block multiplies two elements of the binary field GF(2^163) in polynomial basis and delivers the reduced product one clock after the operands are presented. Operand B is cut into 41-bit digits: three full digits and a final digit of 40 bits. Each digit is multiplied carry-free by the whole of operand A at the same time. The partial products are shifted to their digit positions and XOR-merged into a 325-bit unreduced polynomial. That polynomial is then folded back below degree 163 with fixed shifts taken from the field polynomial x^163 + x^7 + x^6 + x^3 + 1.

A squaring stage follows the reducer. It spreads the reduced product by placing a zero after every bit, then reduces the result again. When a control input is set, the registered output is (A·B)^2 instead of A·B. Presenting the same value on both operands therefore yields A^4 in a single pass. This is useful in point-multiplication datapaths and in inversion chains built from repeated squarings.

Top module: `gf_digit_mul`

## Requirements
- R1: With `sq_i` low, `res_o` equals A·B mod (x^163 + x^7 + x^6 + x^3 + 1) in the cycle after the edge at which `valid_i` was sampled high. Bit i of an operand or result is the coefficient of x^i.
- R2: `valid_o` is high in exactly the cycles that follow an edge at which `valid_i` was high.
- R3: With `sq_i` high, `res_o` equals (A·B)^2 reduced by the same field polynomial.
- R4: With A = B and `sq_i` high, `res_o` equals A^4 reduced.
- R5: Multiplying by the polynomial 1 (value 1 on `b_i`) with `sq_i` low returns `a_i` unchanged.
- R6: If either operand is zero, the result is zero, in both modes.
- R7: When `valid_i` is low at an edge, `res_o` keeps its value, whatever `a_i`, `b_i` and `sq_i` carry.
- R8: While `rst_ni` is low, `res_o` is zero and `valid_o` is low.
- R9: Reduction wraps x^163 onto x^7 + x^6 + x^3 + 1, so x^162 · x gives the value 0xC9. Every result has degree below 163.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present; result loads at this edge |
| sq_i | input | 1 | 1: output the square of the product; 0: output the product |
| a_i | input | 163 | Operand A |
| b_i | input | 163 | Operand B, split into digits |
| valid_o | output | 1 | Result register was loaded at the last edge |
| res_o | output | 163 | Registered field result |

## Verification
The bench builds the block with its default parameters: a 163-bit field and 41-bit digits, which gives four digits with a short last digit. It can therefore reach the case where the top bit of B lands in the 40-bit digit, and the case where x^162 products overflow into the two-pass fold. All-ones operands exercise every partial-product column and every fold tap at once. Single-bit operands reach the exact wrap of x^163 and the squaring of high-degree terms.

// File: rtl/gf_digit_mul_pkg.sv
package gf_digit_mul_pkg;
  localparam int unsigned FIELD_M = 163;
  localparam int unsigned DIGIT_W = 41;
  // low terms of the field polynomial: x^7 + x^6 + x^3 + 1
  localparam logic [FIELD_M-1:0] POLY_LOW = FIELD_M'(8'hC9);
  localparam int unsigned FOLD_PASSES = 2;

  function automatic int unsigned digit_count(int unsigned m, int unsigned d);
    return (m + d - 1) / d;
  endfunction
endpackage

// File: rtl/gf_digit_core.sv
module gf_digit_core #(
  parameter int unsigned M = gf_digit_mul_pkg::FIELD_M,
  parameter int unsigned D = gf_digit_mul_pkg::DIGIT_W
) (
  input  logic [M-1:0]   a_i,
  input  logic [M-1:0]   b_i,
  output logic [2*M-2:0] prod_o
);
  localparam int unsigned NDIG = gf_digit_mul_pkg::digit_count(M, D);
  localparam int unsigned PPW  = D + M - 1;
  localparam int unsigned BW   = NDIG * D;
  localparam int unsigned AW   = BW + M - 1;
  localparam int unsigned PW   = 2 * M - 1;

  logic [BW-1:0]             b_pad;
  logic [NDIG-1:0][PPW-1:0]  pp;
  logic [AW-1:0]             acc;

  assign b_pad = BW'(b_i);

  // one carry-free digit-by-operand product per digit, all in parallel
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [D-1:0]   dig;
    logic [PPW-1:0] pp_g;
    assign dig = b_pad[g*D +: D];
    always_comb begin
      pp_g = '0;
      for (int j = 0; j < int'(D); j++) begin
        if (dig[j]) pp_g = pp_g ^ (PPW'(a_i) << j);
      end
    end
    assign pp[g] = pp_g;
  end

  always_comb begin
    acc = '0;
    for (int g = 0; g < int'(NDIG); g++) begin
      acc = acc ^ (AW'(pp[g]) << (g * int'(D)));
    end
  end

  assign prod_o = acc[PW-1:0];

  // padding digits are zero, so nothing may land above degree 2M-2
  always_comb begin
    if (acc[AW-1:PW] != '0) assert_acc_top_r1: assert (1'b0)
      else $error("p_acc_top_r1: merged product exceeds 2M-1 bits");
  end

  always_comb begin
    if (b_i == '0) begin
      p_zero_core_r6: assert (prod_o == '0)
        else $error("p_zero_core_r6: zero digit set gave nonzero product");
    end
  end
endmodule

// File: rtl/gf_reduce.sv
module gf_reduce #(
  parameter int unsigned     M        = gf_digit_mul_pkg::FIELD_M,
  parameter logic [M-1:0]    POLY_LOW = gf_digit_mul_pkg::POLY_LOW,
  parameter int unsigned     PASSES   = gf_digit_mul_pkg::FOLD_PASSES
) (
  input  logic [2*M-2:0] c_i,
  output logic [M-1:0]   r_o
);
  localparam int unsigned W  = 2 * M - 1;
  localparam int unsigned HW = M - 1;

  logic [W-1:0]  t;
  logic [HW-1:0] hi;

  // fold the part above x^(M-1) back with fixed shifts, a few passes
  always_comb begin
    t  = c_i;
    hi = '0;
    for (int p = 0; p < int'(PASSES); p++) begin
      hi = t[W-1:M];
      t[W-1:M] = '0;
      for (int k = 0; k < int'(M); k++) begin
        if (POLY_LOW[k]) t = t ^ (W'(hi) << k);
      end
    end
  end

  assign r_o = t[M-1:0];

  always_comb begin
    p_fold_done_r9: assert (t[W-1:M] == '0)
      else $error("p_fold_done_r9: residue above degree M-1 after folding");
  end
endmodule

// File: rtl/gf_square.sv
module gf_square #(
  parameter int unsigned M = gf_digit_mul_pkg::FIELD_M
) (
  input  logic [M-1:0] a_i,
  output logic [M-1:0] sq_o
);
  logic [2*M-2:0] spread;

  always_comb begin
    spread = '0;
    for (int i = 0; i < int'(M); i++) spread[2*i] = a_i[i];
  end

  gf_reduce #(.M(M)) u_red (
    .c_i (spread),
    .r_o (sq_o)
  );
endmodule

// File: rtl/gf_digit_mul.sv
module gf_digit_mul #(
  parameter int unsigned M = gf_digit_mul_pkg::FIELD_M,
  parameter int unsigned D = gf_digit_mul_pkg::DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sq_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         valid_o,
  output logic [M-1:0] res_o
);
  logic [2*M-2:0] prod_raw;
  logic [M-1:0]   prod_red;
  logic [M-1:0]   prod_sq;
  logic [M-1:0]   res_d;

  gf_digit_core #(.M(M), .D(D)) u_core (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_raw)
  );

  gf_reduce #(.M(M)) u_red (
    .c_i (prod_raw),
    .r_o (prod_red)
  );

  gf_square #(.M(M)) u_sq (
    .a_i  (prod_red),
    .sq_o (prod_sq)
  );

  assign res_d = sq_i ? prod_sq : prod_red;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o)
    else $error("p_valid_lat_r2");

  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o)
    else $error("p_valid_idle_r2");

  p_mul_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sq_i && b_i == M'(1)) |=> res_o == $past(a_i))
    else $error("p_mul_one_r5");

  p_mul_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (a_i == '0 || b_i == '0)) |=> res_o == '0)
    else $error("p_mul_zero_r6");

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o))
    else $error("p_hold_r7");
endmodule

// File: tb/sim_gf_digit_mul.sv
module sim_gf_digit_mul;
  localparam int CLK_PERIOD = 10;
  localparam int M = 163;
  localparam int NV = 6;
  localparam logic [M-1:0] ONES = {M{1'b1}};

  localparam logic [M-1:0] TA [NV] = '{
    ONES, ONES, M'(1) << 162,
    M'(128'h1234_5678_9abc_def0_0fed_cba9_8765_4321) ^ (M'(1) << 160),
    M'(96'hdead_beef_cafe_f00d_0bad_c0de), M'(1) << 100};
  localparam logic [M-1:0] TB [NV] = '{
    ONES, M'(1), M'(2),
    M'(112'h5555_aaaa_3333_cccc_0f0f_f0f0_1357) ^ (M'(1) << 162),
    M'(96'hdead_beef_cafe_f00d_0bad_c0de), M'(1) << 90};
  localparam logic TS [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic sq_i = 1'b0;
  logic [M-1:0] a_i = '0;
  logic [M-1:0] b_i = '0;
  logic valid_o;
  logic [M-1:0] res_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_digit_mul u0 (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i), .sq_i (sq_i),
    .a_i (a_i), .b_i (b_i), .valid_o (valid_o), .res_o (res_o)
  );

  // bit-serial reference: Horner over bits of b, reduce each step
  function automatic logic [M-1:0] xtime(input logic [M-1:0] v);
    logic [M-1:0] s;
    s = v << 1;
    if (v[M-1]) s = s ^ M'(8'hC9);
    return s;
  endfunction

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = xtime(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [191:0] w;
    w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    return w[M-1:0];
  endfunction

  task automatic check(input logic [M-1:0] got, input logic [M-1:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // drive at negedge, load at posedge, observe at following negedge
  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input logic s,
                        input logic [M-1:0] exp, input string tag);
    @(negedge clk);
    a_i = a; b_i = b; sq_i = s; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(res_o, exp, tag);
    check(M'(valid_o), M'(1), "R2 valid_o after valid_i");
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [M-1:0] a, b, p, e;
    // R8 reset state
    #(CLK_PERIOD * 2 + 1);
    check(res_o, '0, "R8 res_o in reset");
    check(M'(valid_o), '0, "R8 valid_o in reset");
    @(negedge clk);
    rst_ni = 1'b1;

    // table: R1/R3/R4/R5/R9 cases
    for (int v = 0; v < NV; v++) begin
      p = ref_mul(TA[v], TB[v]);
      e = TS[v] ? ref_mul(p, p) : p;
      run_op(TA[v], TB[v], TS[v], e, TS[v] ? "R3 table squared product" : "R1 table product");
    end

    // R9 exact wrap of x^163
    run_op(M'(1) << 162, M'(2), 1'b0, M'(8'hC9), "R9 x^162*x wraps to C9");
    // R5 identity
    a = rnd();
    run_op(a, M'(1), 1'b0, a, "R5 times one");
    run_op(M'(1), a, 1'b0, a, "R5 one times a");
    // R6 zero in both modes
    run_op(a, '0, 1'b0, '0, "R6 times zero");
    run_op('0, ONES, 1'b1, '0, "R6 zero squared mode");
    // R4 A^4 with same operand
    a = rnd();
    p = ref_mul(a, a);
    run_op(a, a, 1'b1, ref_mul(p, p), "R4 fourth power");
    run_op(ONES, ONES, 1'b1, ref_mul(ref_mul(ONES, ONES), ref_mul(ONES, ONES)), "R4 all-ones fourth power");

    // R7 hold while valid_i low; R2 valid_o drops
    e = res_o;
    @(negedge clk);
    a_i = rnd(); b_i = rnd(); sq_i = ~sq_i;
    @(negedge clk);
    check(res_o, e, "R7 hold with idle valid_i");
    check(M'(valid_o), '0, "R2 valid_o low when idle");

    // random single-bit operands
    for (int i = 0; i < 20; i++) begin
      a = M'(1) << ($urandom % M);
      b = M'(1) << ($urandom % M);
      run_op(a, b, i[0], i[0] ? ref_mul(ref_mul(a, b), ref_mul(a, b)) : ref_mul(a, b),
             "R1 single-bit operands");
    end
    // random dense operands
    for (int i = 0; i < 40; i++) begin
      a = rnd(); b = rnd();
      p = ref_mul(a, b);
      run_op(a, b, i[0], i[0] ? ref_mul(p, p) : p,
             i[0] ? "R3 random squared" : "R1 random product");
    end

    // R8 asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(res_o, '0, "R8 async reset clears res_o");
    check(M'(valid_o), '0, "R8 async reset clears valid_o");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule